// File: doc/BRIEF.md
# Three-Channel Temperature Alarm Register Bank

This block holds the alarm state of a small temperature monitor. A sensing front end delivers one signed temperature sample at a time, tagged with its channel number and qualified by a valid strobe. For each channel, the block keeps the latest accepted sample and three programmable signed limits: low, high and overtemperature. Every accepted sample is compared against those three limits. A limit that is crossed sets a warning flag that stays set. Software clears a flag by writing a one to its bit. If the condition still holds at the next accepted sample, the flag sets again.

Software reaches the block through a byte-wide register port with a write strobe and a combinational read. A channel-select register chooses which channel the per-channel registers address. A standby bit suspends all comparison; it comes out of reset set. A single overtemperature pin is high while any enabled channel holds its overtemperature flag. The pin follows the sticky flag, not the live comparison, so it stays asserted until software clears the flag.

Top module: `tmon_regbank`

## Requirements
- R1: After reset, the block is in standby (offset 0x08 reads 0x01) and the select register (offset 0x09) reads 0. The pin is low. In every channel, config/status reads 0x00, the sample register reads 0, the high and overtemperature limits read 0x7F, and the low limit reads 0x80.
- R2: Bit 0 of offset 0x08 is the standby bit; it takes the written value and reads back. While it is 1, samples are ignored: the sample register, the flags and the pin hold.
- R3: The value in offset 0x09 picks the channel that offsets 0x0A to 0x0E address. A select value of 3 or above makes reads of those offsets return 0 and makes writes to them have no effect on any channel.
- R4: An accepted sample is stored in the channel's sample register (offset 0x0B) as a signed byte. A sample is accepted when the strobe is high, the block is out of standby and the channel is enabled.
- R5: Config/status bit 1 (low warning) sets when an accepted sample is at or below the low limit (offset 0x0D). The comparison is signed.
- R6: Config/status bit 2 (high warning) sets when an accepted sample is at or above the high limit (offset 0x0C).
- R7: Config/status bit 3 (overtemperature warning) sets when an accepted sample is at or above the overtemperature limit (offset 0x0E).
- R8: Warning bits are sticky. Writing 1 clears a bit and writing 0 leaves it unchanged. Bit 0 (channel enable) takes the written value. If a set and a clear of the same bit fall in one cycle, the set wins. A cleared flag sets again on the next accepted sample that meets its condition.
- R9: A disabled channel ignores samples: its sample register and flags hold their values.
- R10: The pin is high exactly while some channel has both bit 0 and bit 3 of its config/status set. It falls when that flag is cleared or that channel is disabled.
- R11: Config/status bit 6 records the front end's open-sensor indicator that came with the last accepted sample.
- R12: Offsets outside 0x08 to 0x0E read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (4) | Register offset |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data for `addr`, combinational |
| smp_valid | input | 1 | Sample strobe from the front end |
| smp_chan | input | CW (2) | Channel of the sample |
| smp_temp | input | TW (8) | Signed sample in whole degrees |
| smp_open | input | 1 | Open-sensor indicator with the sample |
| ot_pin | output | 1 | Overtemperature pin |

## Verification
The bench builds the block with its default values: three channels, an 8-bit temperature and 8-bit registers. With three channels, a 2-bit select held in an 8-bit register can address a channel that does not exist, so the out-of-range path of the select is exercised. The 8-bit signed width lets the bench use the signed extremes -128 and +127 as reset limits and as samples. This exposes any unsigned comparison, and it places the equal-to-limit boundaries where they can be hit exactly. The bench also drives a write and a sample in the same cycle on one channel, which checks that a set takes priority over a clear.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
   // register offsets; software decodes these
   localparam logic [3:0] OFF_STBY = 4'h8;
   localparam logic [3:0] OFF_SEL  = 4'h9;
   localparam logic [3:0] OFF_CFG  = 4'hA;
   localparam logic [3:0] OFF_TEMP = 4'hB;
   localparam logic [3:0] OFF_HI   = 4'hC;
   localparam logic [3:0] OFF_LO   = 4'hD;
   localparam logic [3:0] OFF_OT   = 4'hE;

   // bit positions within the config/status byte
   localparam int CFG_EN   = 0;
   localparam int CFG_LO   = 1;
   localparam int CFG_HI   = 2;
   localparam int CFG_OT   = 3;
   localparam int CFG_OPEN = 6;

   typedef struct packed {
      logic en;
      logic lo;
      logic hi;
      logic ot;
      logic open;
   } ch_stat_t;
endpackage

// File: rtl/tmon_chan.sv
module tmon_chan
   import tmon_pkg::*;
#(
   parameter int TW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          smp_hit,
   input  logic [TW-1:0] smp_temp,
   input  logic          smp_open,
   input  logic          wr_cfg,
   input  logic          wr_hi,
   input  logic          wr_lo,
   input  logic          wr_ot,
   input  logic [DW-1:0] wdata,
   output ch_stat_t      stat,
   output logic [TW-1:0] temp,
   output logic [TW-1:0] lim_hi,
   output logic [TW-1:0] lim_lo,
   output logic [TW-1:0] lim_ot
);
   localparam logic [TW-1:0] S_MAX = {1'b0, {(TW-1){1'b1}}};
   localparam logic [TW-1:0] S_MIN = {1'b1, {(TW-1){1'b0}}};

   logic accept, set_lo, set_hi, set_ot;
   logic clr_lo, clr_hi, clr_ot;

   always_comb begin
      accept = smp_hit && active && stat.en;
      set_lo = accept && ($signed(smp_temp) <= $signed(lim_lo));
      set_hi = accept && ($signed(smp_temp) >= $signed(lim_hi));
      set_ot = accept && ($signed(smp_temp) >= $signed(lim_ot));
      clr_lo = wr_cfg && wdata[CFG_LO];
      clr_hi = wr_cfg && wdata[CFG_HI];
      clr_ot = wr_cfg && wdata[CFG_OT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat   <= '0;
         temp   <= '0;
         lim_hi <= S_MAX;
         lim_lo <= S_MIN;
         lim_ot <= S_MAX;
      end else begin
         if (wr_cfg) stat.en <= wdata[CFG_EN];
         // clear first, then set: a set in the same cycle wins
         stat.lo <= (stat.lo && !clr_lo) || set_lo;
         stat.hi <= (stat.hi && !clr_hi) || set_hi;
         stat.ot <= (stat.ot && !clr_ot) || set_ot;
         if (accept) begin
            temp      <= smp_temp;
            stat.open <= smp_open;
         end
         if (wr_hi) lim_hi <= wdata[TW-1:0];
         if (wr_lo) lim_lo <= wdata[TW-1:0];
         if (wr_ot) lim_ot <= wdata[TW-1:0];
      end
   end
endmodule

// File: rtl/tmon_rdmux.sv
module tmon_rdmux
   import tmon_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int TW     = 8,
   parameter int DW     = 8,
   parameter int AW     = 4
) (
   input  logic [AW-1:0]                addr,
   input  logic [DW-1:0]                sel,
   input  logic                         stby,
   input  ch_stat_t [NUM_CH-1:0]        stat,
   input  logic [NUM_CH-1:0][TW-1:0]    temp,
   input  logic [NUM_CH-1:0][TW-1:0]    lim_hi,
   input  logic [NUM_CH-1:0][TW-1:0]    lim_lo,
   input  logic [NUM_CH-1:0][TW-1:0]    lim_ot,
   output logic [DW-1:0]                rdata
);
   function automatic logic [DW-1:0] cfg_byte(input ch_stat_t s);
      logic [DW-1:0] r;
      r           = '0;
      r[CFG_EN]   = s.en;
      r[CFG_LO]   = s.lo;
      r[CFG_HI]   = s.hi;
      r[CFG_OT]   = s.ot;
      r[CFG_OPEN] = s.open;
      return r;
   endfunction

   function automatic logic [DW-1:0] sext(input logic [TW-1:0] v);
      return DW'($signed(v));
   endfunction

   logic [DW-1:0] ch_word;

   always_comb begin
      ch_word = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (sel == DW'(i)) begin
            case (addr)
               AW'(OFF_CFG):  ch_word = cfg_byte(stat[i]);
               AW'(OFF_TEMP): ch_word = sext(temp[i]);
               AW'(OFF_HI):   ch_word = sext(lim_hi[i]);
               AW'(OFF_LO):   ch_word = sext(lim_lo[i]);
               AW'(OFF_OT):   ch_word = sext(lim_ot[i]);
               default:       ch_word = '0;
            endcase
         end
      end
   end

   always_comb begin
      case (addr)
         AW'(OFF_STBY): rdata = DW'(stby);
         AW'(OFF_SEL):  rdata = sel;
         default:       rdata = ch_word;
      endcase
   end
endmodule

// File: rtl/tmon_regbank.sv
module tmon_regbank
   import tmon_pkg::*;
#(
   parameter int   NUM_CH     = 3,
   parameter int   TW         = 8,
   parameter int   DW         = 8,
   parameter int   AW         = 4,
   parameter logic STBY_RESET = 1'b1,
   localparam int  CW         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          smp_valid,
   input  logic [CW-1:0] smp_chan,
   input  logic [TW-1:0] smp_temp,
   input  logic          smp_open,
   output logic          ot_pin
);
   generate
      if (NUM_CH < 1 || NUM_CH > (1 << (DW - 1)))
         $error("tmon_regbank: NUM_CH out of range");
      if (TW < 2 || TW > DW)
         $error("tmon_regbank: TW must lie in 2..DW");
      if (DW < 8)
         $error("tmon_regbank: DW must be at least 8");
      if (AW < 4)
         $error("tmon_regbank: AW must be at least 4");
   endgenerate

   logic                      stby_q;
   logic [DW-1:0]             sel_q;
   ch_stat_t [NUM_CH-1:0]     ch_stat;
   logic [NUM_CH-1:0][TW-1:0] ch_temp, ch_hi, ch_lo, ch_ot;
   logic [NUM_CH-1:0]         ch_alarm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stby_q <= STBY_RESET;
         sel_q  <= '0;
      end else if (wr_en) begin
         if (addr == AW'(OFF_STBY)) stby_q <= wdata[0];
         if (addr == AW'(OFF_SEL))  sel_q  <= wdata;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit_sel;
      assign hit_sel = wr_en && (sel_q == DW'(c));

      tmon_chan #(.TW(TW), .DW(DW)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (!stby_q),
         .smp_hit  (smp_valid && (smp_chan == CW'(c))),
         .smp_temp (smp_temp),
         .smp_open (smp_open),
         .wr_cfg   (hit_sel && (addr == AW'(OFF_CFG))),
         .wr_hi    (hit_sel && (addr == AW'(OFF_HI))),
         .wr_lo    (hit_sel && (addr == AW'(OFF_LO))),
         .wr_ot    (hit_sel && (addr == AW'(OFF_OT))),
         .wdata    (wdata),
         .stat     (ch_stat[c]),
         .temp     (ch_temp[c]),
         .lim_hi   (ch_hi[c]),
         .lim_lo   (ch_lo[c]),
         .lim_ot   (ch_ot[c])
      );

      assign ch_alarm[c] = ch_stat[c].en && ch_stat[c].ot;
   end

   assign ot_pin = |ch_alarm;

   tmon_rdmux #(.NUM_CH(NUM_CH), .TW(TW), .DW(DW), .AW(AW)) u_rdmux (
      .addr   (addr),
      .sel    (sel_q),
      .stby   (stby_q),
      .stat   (ch_stat),
      .temp   (ch_temp),
      .lim_hi (ch_hi),
      .lim_lo (ch_lo),
      .lim_ot (ch_ot),
      .rdata  (rdata)
   );
endmodule

// File: rtl/tmon_chk.sv
module tmon_chk
   import tmon_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int TW     = 8,
   parameter int DW     = 8,
   parameter int AW     = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_en,
   input logic [AW-1:0]             addr,
   input logic [DW-1:0]             rdata,
   input logic                      smp_valid,
   input logic                      ot_pin,
   input logic                      stby_q,
   input logic [DW-1:0]             sel_q,
   input logic [NUM_CH-1:0][TW-1:0] ch_temp
);
   logic per_ch, unmapped;
   assign per_ch   = (addr >= AW'(OFF_CFG)) && (addr <= AW'(OFF_OT));
   assign unmapped = (addr < AW'(OFF_STBY)) || (addr > AW'(OFF_OT));

   // R2
   stby_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_q && !wr_en) |=> ($stable(ch_temp) && $stable(ot_pin)));

   // R3
   sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (per_ch && (sel_q >= DW'(NUM_CH))) |-> (rdata == '0));

   // R8
   pin_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ot_pin) |-> $past(wr_en));

   // R10
   pin_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ot_pin) |-> ($past(smp_valid) || $past(wr_en)));

   // R12
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (rdata == '0));
endmodule

bind tmon_regbank tmon_chk #(.NUM_CH(NUM_CH), .TW(TW), .DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .rdata     (rdata),
   .smp_valid (smp_valid),
   .ot_pin    (ot_pin),
   .stby_q    (stby_q),
   .sel_q     (sel_q),
   .ch_temp   (ch_temp)
);

// File: tb/tmon_regbank_bench.sv
module tmon_regbank_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       smp_valid = 1'b0;
   logic [1:0] smp_chan = '0;
   logic [7:0] smp_temp = '0;
   logic       smp_open = 1'b0;
   logic       ot_pin;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   tmon_regbank u_tmon_regbank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .smp_valid(smp_valid), .smp_chan(smp_chan),
      .smp_temp(smp_temp), .smp_open(smp_open), .ot_pin(ot_pin)
   );

   // op: 0 write a<=d, 1 sample (a[1:0] channel, a[2] open, d temp),
   //     2 read a expect e, 3 pin expect e[0]; r = requirement number
   typedef struct packed {
      logic [1:0] op;
      logic [3:0] a;
      logic [7:0] d;
      logic [7:0] e;
      logic [3:0] r;
   } vec_t;

   localparam vec_t VT [61] = '{
      '{2'd2, 4'h8, 8'h00, 8'h01, 4'd1},   // R1 standby after reset
      '{2'd2, 4'hC, 8'h00, 8'h7F, 4'd1},   // R1
      '{2'd2, 4'hD, 8'h00, 8'h80, 4'd1},   // R1
      '{2'd2, 4'hE, 8'h00, 8'h7F, 4'd1},   // R1
      '{2'd2, 4'hA, 8'h00, 8'h00, 4'd1},   // R1
      '{2'd3, 4'h0, 8'h00, 8'h00, 4'd1},   // R1 pin low
      '{2'd1, 4'h0, 8'h50, 8'h00, 4'd2},
      '{2'd2, 4'hB, 8'h00, 8'h00, 4'd2},   // R2 ignored in standby
      '{2'd0, 4'h8, 8'h00, 8'h00, 4'd2},
      '{2'd2, 4'h8, 8'h00, 8'h00, 4'd2},   // R2 woken
      '{2'd1, 4'h0, 8'h50, 8'h00, 4'd9},
      '{2'd2, 4'hB, 8'h00, 8'h00, 4'd9},   // R9 disabled channel
      '{2'd0, 4'hA, 8'h01, 8'h00, 4'd8},
      '{2'd2, 4'hA, 8'h00, 8'h01, 4'd8},   // R8 enable takes value
      '{2'd0, 4'hC, 8'h40, 8'h00, 4'd6},
      '{2'd0, 4'hE, 8'h60, 8'h00, 4'd7},
      '{2'd0, 4'hD, 8'hF6, 8'h00, 4'd5},
      '{2'd1, 4'h0, 8'h40, 8'h00, 4'd6},
      '{2'd2, 4'hA, 8'h00, 8'h05, 4'd6},   // R6 equal to high limit
      '{2'd2, 4'hB, 8'h00, 8'h40, 4'd4},   // R4
      '{2'd1, 4'h0, 8'h3F, 8'h00, 4'd8},
      '{2'd2, 4'hA, 8'h00, 8'h05, 4'd8},   // R8 sticky
      '{2'd2, 4'hB, 8'h00, 8'h3F, 4'd4},   // R4
      '{2'd0, 4'hA, 8'h05, 8'h00, 4'd8},
      '{2'd2, 4'hA, 8'h00, 8'h01, 4'd8},   // R8 write one clears
      '{2'd1, 4'h0, 8'h60, 8'h00, 4'd7},
      '{2'd2, 4'hA, 8'h00, 8'h0D, 4'd7},   // R7 equal to ot limit
      '{2'd3, 4'h0, 8'h00, 8'h01, 4'd10},  // R10
      '{2'd0, 4'hA, 8'h01, 8'h00, 4'd8},
      '{2'd2, 4'hA, 8'h00, 8'h0D, 4'd8},   // R8 write zero keeps
      '{2'd0, 4'hA, 8'h09, 8'h00, 4'd10},
      '{2'd3, 4'h0, 8'h00, 8'h00, 4'd10},  // R10 falls on clear
      '{2'd2, 4'hA, 8'h00, 8'h05, 4'd8},   // R8
      '{2'd1, 4'h0, 8'hF6, 8'h00, 4'd5},
      '{2'd2, 4'hA, 8'h00, 8'h07, 4'd5},   // R5 equal to low limit
      '{2'd0, 4'hA, 8'h03, 8'h00, 4'd5},
      '{2'd1, 4'h0, 8'hF7, 8'h00, 4'd5},
      '{2'd2, 4'hA, 8'h00, 8'h05, 4'd5},   // R5 one above low limit
      '{2'd1, 4'h0, 8'h80, 8'h00, 4'd5},
      '{2'd2, 4'hA, 8'h00, 8'h07, 4'd5},   // R5 signed minimum
      '{2'd1, 4'h4, 8'h00, 8'h00, 4'd11},
      '{2'd2, 4'hA, 8'h00, 8'h47, 4'd11},  // R11 open flagged
      '{2'd1, 4'h0, 8'h00, 8'h00, 4'd11},
      '{2'd2, 4'hA, 8'h00, 8'h07, 4'd11},  // R11 open gone
      '{2'd0, 4'h9, 8'h01, 8'h00, 4'd3},
      '{2'd2, 4'hA, 8'h00, 8'h00, 4'd3},   // R3 channel 1 fresh
      '{2'd0, 4'h9, 8'h03, 8'h00, 4'd3},
      '{2'd2, 4'hA, 8'h00, 8'h00, 4'd3},   // R3 select out of range
      '{2'd0, 4'hC, 8'h11, 8'h00, 4'd3},
      '{2'd2, 4'hC, 8'h00, 8'h00, 4'd3},   // R3
      '{2'd0, 4'h9, 8'h00, 8'h00, 4'd3},
      '{2'd2, 4'hC, 8'h00, 8'h40, 4'd3},   // R3 channel 0 untouched
      '{2'd2, 4'hF, 8'h00, 8'h00, 4'd12},  // R12
      '{2'd0, 4'h9, 8'h02, 8'h00, 4'd10},
      '{2'd0, 4'hA, 8'h01, 8'h00, 4'd10},
      '{2'd0, 4'hE, 8'h10, 8'h00, 4'd10},
      '{2'd1, 4'h2, 8'h10, 8'h00, 4'd10},
      '{2'd3, 4'h0, 8'h00, 8'h01, 4'd10},  // R10 channel 2 alarm
      '{2'd0, 4'hA, 8'h00, 8'h00, 4'd10},
      '{2'd3, 4'h0, 8'h00, 8'h00, 4'd10},  // R10 falls on disable
      '{2'd2, 4'hA, 8'h00, 8'h08, 4'd9}    // R9 flags held
   };

   task automatic check(input logic [7:0] act, input logic [7:0] exp_v, input string tag);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
      end
   endtask

   task automatic do_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_sample(input logic [1:0] c, input logic [7:0] t, input logic op);
      @(negedge clk);
      smp_valid = 1'b1; smp_chan = c; smp_temp = t; smp_open = op;
      @(negedge clk);
      smp_valid = 1'b0; smp_open = 1'b0;
   endtask

   task automatic read_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
      addr = a;
      #1;
      check(rdata, e, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VT[i]) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VT[i].r, i);
         case (VT[i].op)
            2'd0: do_write(VT[i].a, VT[i].d);
            2'd1: do_sample(VT[i].a[1:0], VT[i].d, VT[i].a[2]);
            2'd2: read_chk(VT[i].a, VT[i].e, tag);
            default: begin #1; check({7'b0, ot_pin}, VT[i].e, tag); end
         endcase
      end

      // R2: standby freezes channel 0 (enabled, temp 0x00, flags 0x07)
      do_write(4'h9, 8'h00);
      do_write(4'h8, 8'h01);
      do_sample(2'd0, 8'h70, 1'b0);
      read_chk(4'hB, 8'h00, "R2 standby holds sample");
      read_chk(4'hA, 8'h07, "R2 standby holds flags");
      #1 check({7'b0, ot_pin}, 8'h00, "R2 standby pin");
      do_write(4'h8, 8'h00);

      // R8: set wins over a clear in the same cycle
      do_sample(2'd0, 8'h70, 1'b0);
      read_chk(4'hA, 8'h0F, "R8 all flags set");
      @(negedge clk);
      wr_en = 1'b1; addr = 4'hA; wdata = 8'h09;
      smp_valid = 1'b1; smp_chan = 2'd0; smp_temp = 8'h70;
      @(negedge clk);
      wr_en = 1'b0; smp_valid = 1'b0;
      read_chk(4'hA, 8'h0F, "R8 set beats clear");
      #1 check({7'b0, ot_pin}, 8'h01, "R10 pin held by set");

      // R8: cleared flag sets again on the next qualifying sample
      do_write(4'hA, 8'h0F);
      read_chk(4'hA, 8'h01, "R8 all cleared");
      do_sample(2'd0, 8'h70, 1'b0);
      read_chk(4'hA, 8'h0D, "R8 flags re-set");

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      read_chk(4'h8, 8'h01, "R1 standby after mid-run reset");
      read_chk(4'hA, 8'h00, "R1 channel cleared by reset");
      read_chk(4'hB, 8'h00, "R1 sample cleared by reset");
      #1 check({7'b0, ot_pin}, 8'h00, "R1 pin after reset");

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule